// File: doc/BRIEF.md
# Bus Driver Fault Gate with Short Debounce

This block sits between the logic that decides what each of two bus lines should carry and the two line drivers. For every bus it takes a dominant request and decides whether that request may actually switch the driver on. A request is blocked when the bus is disabled, when both drivers are off because of over-temperature, while the power-on hold is active, or when that bus's low wire has a confirmed short to the battery supply.

The short indication from each bus's comparator is raw and may chatter. It is therefore filtered in both directions. A short must be present for an unbroken run of cycles before it is accepted. A clean line must be present for a longer unbroken run before the short is cleared again. Any break in a run restarts the count. A confirmed short turns off only its own driver. The other bus, and the receive logic of both buses, carry on as before. The filtered flags are exported for observation.

Top module: `drv_fault_gate`

## Requirements
- R1: A short on bus i is confirmed (`fault_flag[i]` goes to 1) on the ASSERT_CYC-th consecutive rising edge at which `short_raw[i]` is sampled 1. A run of fewer edges leaves the flag at 0.
- R2: A confirmed short clears (`fault_flag[i]` goes to 0) on the RELEASE_CYC-th consecutive rising edge at which `short_raw[i]` is sampled 0. RELEASE_CYC is a separate parameter from ASSERT_CYC and defaults to a longer value.
- R3: When the raw flag returns to the current filtered state before its run is complete, the run count restarts from zero.
- R4: While `fault_flag[i]` is 1, `drv_on[i]` is 0. The other bus's driver and its flag are unaffected.
- R5: While `overtemp` is 1, both `drv_on` bits are 0. The short filters keep running and the flags keep their values.
- R6: While `bus_en_n[i]` is 1 (bus disabled), `drv_on[i]` is 0, the same as a recessive request.
- R7: While `por_active` is 1, both drivers are 0. Both filter counters and both flags are cleared at every rising edge.
- R8: `rst` (synchronous, active high) clears both flags and counters.
- R9: Otherwise `drv_on[i]` equals `dom_req[i]` in the same cycle, with no register in the path. A request bit of 1 means dominant and a driver bit of 1 means active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| por_active | input | 1 | Power-on hold: drivers off, filters cleared |
| dom_req | input | NUM_BUS | Dominant request per bus (1 = dominant) |
| bus_en_n | input | NUM_BUS | Per-bus disable (1 = bus switched off) |
| overtemp | input | 1 | Shared over-temperature flag |
| short_raw | input | NUM_BUS | Unfiltered short-to-battery comparator per bus |
| drv_on | output | NUM_BUS | Final driver enable per bus (1 = drive dominant) |
| fault_flag | output | NUM_BUS | Filtered short flag per bus |

## Verification
A short confirmation on one bus can land in the same cycle that over-temperature is raised, or in the same cycle that the other bus is requesting dominant. The bench runs the raw short up to the edge where it is confirmed while over-temperature is held, and checks three things: the flag still rises on exactly that edge, both drivers stay off, and the other bus's flag is untouched. It also confirms a short on one bus while the other bus drives dominant, and checks that only the faulty bus drops. Each cycle is judged against a queue of expected outputs. The expected values come from a run-length model of the requirements.

// File: rtl/drv_fault_gate_pkg.sv
package drv_fault_gate_pkg;

    // Width needed to hold counts up to n.
    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Everything that decides one driver in one cycle.
    typedef struct packed {
        logic want_dom;   // dominant requested
        logic blocked_en; // bus switched off
        logic short_off;  // confirmed short on this bus
        logic heat_off;   // over-temperature
        logic por_hold;   // power-on hold
    } gate_req_t;

endpackage

// File: rtl/short_debounce.sv
module short_debounce
    import drv_fault_gate_pkg::*;
#(
    parameter int ASSERT_CYC  = 4000,
    parameter int RELEASE_CYC = 5500
) (
    input  logic clk,
    input  logic clr,
    input  logic raw,
    output logic flag
);
    localparam int CNT_W = cnt_width(max_int(ASSERT_CYC, RELEASE_CYC));
    localparam logic [CNT_W-1:0] SET_LAST = CNT_W'(ASSERT_CYC - 1);
    localparam logic [CNT_W-1:0] CLR_LAST = CNT_W'(RELEASE_CYC - 1);

    logic [CNT_W-1:0] run_q;
    logic             flag_q;
    logic [CNT_W-1:0] last_c;

    assign last_c = flag_q ? CLR_LAST : SET_LAST;

    always_ff @(posedge clk) begin
        if (clr) begin
            run_q  <= '0;
            flag_q <= 1'b0;
        end else if (raw == flag_q) begin
            run_q <= '0;
        end else if (run_q == last_c) begin
            flag_q <= raw;
            run_q  <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    assign flag = flag_q;
endmodule

// File: rtl/drv_gate_cell.sv
module drv_gate_cell
    import drv_fault_gate_pkg::*;
(
    input  gate_req_t req,
    output logic      drv_on
);
    always_comb begin
        drv_on = req.want_dom;
        if (req.blocked_en || req.short_off || req.heat_off || req.por_hold)
            drv_on = 1'b0;
    end
endmodule

// File: rtl/drv_fault_gate.sv
module drv_fault_gate
    import drv_fault_gate_pkg::*;
#(
    parameter int NUM_BUS     = 2,
    parameter int ASSERT_CYC  = 4000,
    parameter int RELEASE_CYC = 5500
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               por_active,
    input  logic [NUM_BUS-1:0] dom_req,
    input  logic [NUM_BUS-1:0] bus_en_n,
    input  logic               overtemp,
    input  logic [NUM_BUS-1:0] short_raw,
    output logic [NUM_BUS-1:0] drv_on,
    output logic [NUM_BUS-1:0] fault_flag
);
    logic filt_clr;
    assign filt_clr = rst | por_active;

    for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
        gate_req_t req;

        short_debounce #(
            .ASSERT_CYC (ASSERT_CYC),
            .RELEASE_CYC(RELEASE_CYC)
        ) u_deb (
            .clk (clk),
            .clr (filt_clr),
            .raw (short_raw[b]),
            .flag(fault_flag[b])
        );

        assign req = '{want_dom:   dom_req[b],
                       blocked_en: bus_en_n[b],
                       short_off:  fault_flag[b],
                       heat_off:   overtemp,
                       por_hold:   por_active};

        drv_gate_cell u_gate (
            .req   (req),
            .drv_on(drv_on[b])
        );
    end
endmodule

// File: rtl/drv_fault_gate_chk.sv
module drv_fault_gate_chk
    import drv_fault_gate_pkg::*;
#(
    parameter int NUM_BUS     = 2,
    parameter int ASSERT_CYC  = 4000,
    parameter int RELEASE_CYC = 5500
) (
    input logic               clk,
    input logic               rst,
    input logic               por_active,
    input logic [NUM_BUS-1:0] dom_req,
    input logic [NUM_BUS-1:0] bus_en_n,
    input logic               overtemp,
    input logic [NUM_BUS-1:0] short_raw,
    input logic [NUM_BUS-1:0] drv_on,
    input logic [NUM_BUS-1:0] fault_flag
);
    localparam int SAT   = max_int(ASSERT_CYC, RELEASE_CYC);
    localparam int RUN_W = cnt_width(SAT);

    for (genvar b = 0; b < NUM_BUS; b++) begin : g_chk
        logic [RUN_W-1:0] hi_run, lo_run;

        always_ff @(posedge clk) begin
            if (rst || por_active) begin
                hi_run <= '0;
                lo_run <= '0;
            end else if (short_raw[b]) begin
                lo_run <= '0;
                if (hi_run != RUN_W'(SAT)) hi_run <= hi_run + 1'b1;
            end else begin
                hi_run <= '0;
                if (lo_run != RUN_W'(SAT)) lo_run <= lo_run + 1'b1;
            end
        end

        // R1, R3: confirmation only after a full unbroken high run
        a_r1_confirm_after_run: assert property (@(posedge clk)
            disable iff (rst || por_active)
            $rose(fault_flag[b]) |-> (hi_run >= RUN_W'(ASSERT_CYC)));

        // R2, R3: release only after a full unbroken low run
        a_r2_release_after_run: assert property (@(posedge clk)
            disable iff (rst || por_active)
            ($fell(fault_flag[b]) && !$past(por_active) && !$past(rst))
                |-> (lo_run >= RUN_W'(RELEASE_CYC)));

        // R4: a confirmed short keeps its own driver off
        a_r4_short_blocks: assert property (@(posedge clk)
            disable iff (rst)
            fault_flag[b] |-> !drv_on[b]);

        // R6: a disabled bus never drives
        a_r6_disabled_quiet: assert property (@(posedge clk)
            disable iff (rst)
            bus_en_n[b] |-> !drv_on[b]);
    end

    // R5: over-temperature silences both drivers
    a_r5_heat_blocks: assert property (@(posedge clk)
        disable iff (rst)
        overtemp |-> (drv_on == '0));

    // R7: power-on hold silences drivers and clears flags
    a_r7_por_hold: assert property (@(posedge clk)
        disable iff (rst)
        por_active |=> (fault_flag == '0));

    // R8: reset clears flags
    a_r8_reset_clears: assert property (@(posedge clk)
        disable iff (por_active)
        rst |=> (fault_flag == '0));
endmodule

bind drv_fault_gate drv_fault_gate_chk #(
    .NUM_BUS    (NUM_BUS),
    .ASSERT_CYC (ASSERT_CYC),
    .RELEASE_CYC(RELEASE_CYC)
) u_chk (.*);

// File: tb/drv_fault_gate_tb.sv
module drv_fault_gate_tb;
    localparam int NB  = 2;
    localparam int ACY = 6;
    localparam int RCY = 9;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          por_active = 1'b0;
    logic [NB-1:0] dom_req = '0;
    logic [NB-1:0] bus_en_n = '0;
    logic          overtemp = 1'b0;
    logic [NB-1:0] short_raw = '0;
    logic [NB-1:0] drv_on;
    logic [NB-1:0] fault_flag;

    always #2 clk = ~clk;

    drv_fault_gate #(.NUM_BUS(NB), .ASSERT_CYC(ACY), .RELEASE_CYC(RCY)) u_dut (
        .clk(clk), .rst(rst), .por_active(por_active), .dom_req(dom_req),
        .bus_en_n(bus_en_n), .overtemp(overtemp), .short_raw(short_raw),
        .drv_on(drv_on), .fault_flag(fault_flag)
    );

    typedef struct {
        logic [NB-1:0] drv;
        logic [NB-1:0] flt;
        string         tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 0;

    // Run-length model of the requirements
    int   m_run [NB];
    logic m_flag[NB];

    task automatic step(input logic r, input logic p, input logic [NB-1:0] dq,
                        input logic [NB-1:0] en_n, input logic ot,
                        input logic [NB-1:0] sr, input string tag);
        exp_t e;
        @(negedge clk);
        rst = r; por_active = p; dom_req = dq; bus_en_n = en_n;
        overtemp = ot; short_raw = sr;
        for (int b = 0; b < NB; b++) begin
            if (r || p) begin
                m_run[b] = 0; m_flag[b] = 1'b0;
            end else if (sr[b] == m_flag[b]) begin
                m_run[b] = 0;
            end else begin
                m_run[b]++;
                if (m_run[b] == (m_flag[b] ? RCY : ACY)) begin
                    m_flag[b] = sr[b]; m_run[b] = 0;
                end
            end
            e.flt[b] = m_flag[b];
            e.drv[b] = dq[b] && !en_n[b] && !m_flag[b] && !ot && !p;
        end
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compares one expected item per clock, after the edge settles
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() != 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_tests++;
                if (drv_on !== e.drv || fault_flag !== e.flt) begin
                    n_fail++;
                    $display("FAIL %s: drv_on=%b fault_flag=%b expected drv_on=%b fault_flag=%b",
                             e.tag, drv_on, fault_flag, e.drv, e.flt);
                end
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < NB; b++) begin m_run[b] = 0; m_flag[b] = 1'b0; end
        // R8: reset state
        step(1, 0, 2'b11, 2'b00, 0, 2'b11, "R8 reset");
        step(1, 0, 2'b00, 2'b00, 0, 2'b00, "R8 reset");
        // R9: pass-through patterns
        step(0, 0, 2'b01, 2'b00, 0, 2'b00, "R9 pass bus0");
        step(0, 0, 2'b10, 2'b00, 0, 2'b00, "R9 pass bus1");
        step(0, 0, 2'b11, 2'b00, 0, 2'b00, "R9 pass both");
        step(0, 0, 2'b00, 2'b00, 0, 2'b00, "R9 recessive");
        // R6: disable
        step(0, 0, 2'b11, 2'b01, 0, 2'b00, "R6 disable bus0");
        step(0, 0, 2'b11, 2'b10, 0, 2'b00, "R6 disable bus1");
        // R1: run one short of threshold, then break
        for (int k = 0; k < ACY - 1; k++) step(0, 0, 2'b11, 2'b00, 0, 2'b01, "R1 short run");
        step(0, 0, 2'b11, 2'b00, 0, 2'b00, "R3 break before confirm");
        // R1, R4: full run confirms only bus0, bus1 keeps driving
        for (int k = 0; k < ACY; k++) step(0, 0, 2'b11, 2'b00, 0, 2'b01, "R1 R4 confirm bus0");
        step(0, 0, 2'b11, 2'b00, 0, 2'b01, "R4 bus1 unaffected");
        // R5: over-temperature stops both, flag holds
        step(0, 0, 2'b11, 2'b00, 1, 2'b01, "R5 overtemp");
        // R2, R3: release needs longer run, broken once
        for (int k = 0; k < RCY - 1; k++) step(0, 0, 2'b11, 2'b00, 0, 2'b00, "R2 partial release");
        step(0, 0, 2'b11, 2'b00, 0, 2'b01, "R3 break before release");
        for (int k = 0; k < ACY - 1; k++) step(0, 0, 2'b11, 2'b00, 0, 2'b00, "R2 short of release");
        for (int k = 0; k < RCY - ACY + 1; k++) step(0, 0, 2'b11, 2'b00, 0, 2'b00, "R2 release bus0");
        step(0, 0, 2'b11, 2'b00, 0, 2'b00, "R2 bus0 drives again");
        // R5: confirm bus1 while overtemp held, same cycle
        for (int k = 0; k < ACY; k++) step(0, 0, 2'b11, 2'b00, 1, 2'b10, "R5 R1 confirm under overtemp");
        step(0, 0, 2'b11, 2'b00, 0, 2'b10, "R4 bus1 off, bus0 on");
        // R7: power-on hold clears flag and silences drivers
        step(0, 1, 2'b11, 2'b00, 0, 2'b10, "R7 por hold");
        step(0, 1, 2'b11, 2'b00, 0, 2'b11, "R7 por hold counters");
        step(0, 0, 2'b11, 2'b00, 0, 2'b11, "R7 after por, count restarted");
        for (int k = 0; k < ACY - 1; k++) step(0, 0, 2'b11, 2'b00, 0, 2'b11, "R1 both confirm");
        // R8: reset clears both
        step(1, 0, 2'b11, 2'b00, 0, 2'b11, "R8 reset clears flags");
        step(0, 0, 2'b11, 2'b00, 0, 2'b00, "R9 after reset");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule